// File: doc/BRIEF.md
# Virtually indexed, physically tagged data cache lookup

This block is the lookup stage of a 64KB, 16-way set-associative data cache that takes 24-bit virtual byte addresses. Pages are 4KB, so the low 12 address bits pass through translation unchanged. With 64-byte lines there are 64 sets. The set index (address bits 11:6) and the word offset (bits 5:2) therefore both come from that untranslated part. The tag and data arrays can be read with the virtual address while a translation buffer outside the block turns the upper 12 bits into a physical page number in the same cycle.

Each way stores the full physical page number as its tag. A lookup hits when a valid way in the indexed set holds the translated page number. Two virtual pages that map to one physical page share one cached copy. A miss starts a line refill. The block presents the physical line address, takes sixteen 32-bit words in order, and places the line in a way picked by a round-robin pointer kept for each set. A requester that got a miss re-issues its lookup after the refill has ended.

Top module: `vipt_cache`

## Requirements
- R1: After reset, rs_valid and fill_req are low, lk_ready equals xl_ok, and every lookup misses because no way is valid.
- R2: xl_vpn always equals lk_vaddr[23:12]. The set index is lk_vaddr[11:6], the word within the line is lk_vaddr[5:2], and lk_vaddr[1:0] is ignored.
- R3: While xl_ok is low, lk_ready is low, no lookup is accepted and rs_valid stays low in the following cycle.
- R4: A lookup is accepted on a rising edge where lk_valid and lk_ready are both high. rs_valid, rs_hit and rs_data are valid in the cycle that follows. On a hit, rs_data is the addressed 32-bit word.
- R5: After a miss, fill_req is high from the result cycle until the last refill word is taken. fill_paddr is {translated page number, lk_vaddr[11:6], 6'b0} and stays stable. lk_ready is low during the refill.
- R6: The refill takes 16 words on edges where fill_valid is high, beat i holding the word at line byte offset 4*i. Gaps are allowed. After the 16th word, fill_req falls, and lookups of any word in that line hit and return the filled data.
- R7: The hit decision compares physical page numbers. A different virtual page that translates to the same physical page hits on the line already cached.
- R8: The same virtual address translated to a different physical page misses.
- R9: Each set allocates ways in round-robin order. After 16 refills into one set, the 17th refill replaces the line filled first, and the lines in the other ways stay resident.
- R10: At most one way of a set ever matches a lookup.
- R11: fill_valid and fill_word are ignored while no refill is pending. They produce no result and change no cached data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 24 | Virtual byte address of the lookup |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| xl_vpn | output | 12 | Virtual page number sent to the translation buffer |
| xl_ppn | input | 12 | Physical page number returned in the same cycle |
| xl_ok | input | 1 | Translation valid this cycle |
| rs_valid | output | 1 | Result of the lookup accepted in the previous cycle |
| rs_hit | output | 1 | Result is a hit |
| rs_data | output | 32 | Word read on a hit, zero on a miss |
| fill_req | output | 1 | Line refill pending |
| fill_paddr | output | 24 | Physical address of the line to refill |
| fill_valid | input | 1 | Refill word present |
| fill_word | input | 32 | Refill word, in ascending order within the line |

## Verification
The bench builds the block with its default geometry: 64KB, 16 ways, 64-byte lines and 64 sets. At this size a set fills completely after sixteen misses, which is enough to watch the round-robin pointer wrap and evict the oldest line. A translation model with a switchable key and one alias entry lets the bench steer the physical page per lookup. With it the bench can show a shared copy under aliasing and a miss under re-translation of an unchanged virtual address. The refill source pauses once mid-line, and stray refill beats are driven while idle, to exercise both sides of the refill handshake.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 16,
    parameter int PPN_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SETS)-1:0]    lu_set,
    input  logic [PPN_W-1:0]           lu_ppn,
    output logic [WAYS-1:0]            lu_match,
    output logic [$clog2(WAYS)-1:0]    lu_victim,
    input  logic                       alloc_en,
    input  logic                       done_en,
    input  logic [$clog2(SETS)-1:0]    done_set,
    input  logic [$clog2(WAYS)-1:0]    done_way
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ENT   = SETS * WAYS;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];
    logic [PPN_W-1:0] tag_q [ENT];

    assign lu_victim = rr_q[lu_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lu_match[w] = vld_q[lu_set][w] &&
                             (tag_q[{lu_set, WAY_W'(w)}] == lu_ppn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else begin
            if (alloc_en) begin
                vld_q[lu_set][rr_q[lu_set]] <= 1'b0;
            end
            if (done_en) begin
                vld_q[done_set][done_way] <= 1'b1;
                rr_q[done_set]            <= rr_q[done_set] + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            tag_q[{lu_set, rr_q[lu_set]}] <= lu_ppn;
        end
    end

    // R10: a set never holds two valid copies of one physical page
    p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lu_match));

    // R9: each completed refill steps that set's pointer by one
    p_rr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_en |=> rr_q[$past(done_set)] == WAY_W'($past(rr_q[done_set]) + WAY_W'(1)));

    logic [SET_W-1:0] unused_set;
    assign unused_set = done_set;
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 16,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32
) (
    input  logic                                 clk,
    input  logic [$clog2(SETS)-1:0]              rd_set,
    output logic [WAYS-1:0][LINE_W-1:0]          rd_lines,
    input  logic                                 wr_en,
    input  logic [$clog2(SETS)-1:0]              wr_set,
    input  logic [$clog2(WAYS)-1:0]              wr_way,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]     wr_idx,
    input  logic [WORD_W-1:0]                    wr_data
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ENT   = SETS * WAYS;

    logic [LINE_W-1:0] mem_q [ENT];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_lines[w] = mem_q[{rd_set, WAY_W'(w)}];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_set, wr_way}][wr_idx*WORD_W +: WORD_W] <= wr_data;
        end
    end
endmodule

// File: rtl/vipt_way_select.sv
module vipt_way_select #(
    parameter int WAYS   = 16,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32
) (
    input  logic [WAYS-1:0]                      match,
    input  logic [WAYS-1:0][LINE_W-1:0]          lines,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]     widx,
    output logic                                 hit,
    output logic [WORD_W-1:0]                    word
);
    always_comb begin
        word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                word = word | lines[w][widx*WORD_W +: WORD_W];
            end
        end
    end

    assign hit = |match;
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W    = 24,
    parameter int PA_W    = 24,
    parameter int PAGE_W  = 12,
    parameter int CACHE_B = 65536,
    parameter int LINE_B  = 64,
    parameter int WAYS    = 16,
    parameter int WORD_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    output logic                   lk_ready,
    output logic [VA_W-PAGE_W-1:0] xl_vpn,
    input  logic [PA_W-PAGE_W-1:0] xl_ppn,
    input  logic                   xl_ok,
    output logic                   rs_valid,
    output logic                   rs_hit,
    output logic [WORD_W-1:0]      rs_data,
    output logic                   fill_req,
    output logic [PA_W-1:0]        fill_paddr,
    input  logic                   fill_valid,
    input  logic [WORD_W-1:0]      fill_word
);
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PPN_W  = PA_W - PAGE_W;
    localparam int SETS   = CACHE_B / (LINE_B * WAYS);
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_B * 8;
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WIDX_W = $clog2(WPL);
    localparam int BSEL_W = $clog2(WORD_W / 8);

    if (OFF_W + SET_W > PAGE_W) begin : g_geom_check
        $error("set index and line offset must fit in the page offset");
    end

    typedef struct packed {
        vipt_state_e       st;
        logic              rs_valid;
        logic              rs_hit;
        logic [WORD_W-1:0] rs_data;
        logic [SET_W-1:0]  f_set;
        logic [WAY_W-1:0]  f_way;
        logic [WIDX_W-1:0] f_cnt;
        logic [PPN_W-1:0]  f_ppn;
    } ctl_t;

    ctl_t q, d;

    logic [SET_W-1:0]            lk_set;
    logic [WIDX_W-1:0]           lk_widx;
    logic                        accept;
    logic                        alloc;
    logic                        beat;
    logic                        last_beat;
    logic [WAYS-1:0]             match;
    logic [WAY_W-1:0]            victim;
    logic [WAYS-1:0][LINE_W-1:0] lines;
    logic                        hit_any;
    logic [WORD_W-1:0]           hit_word;
    logic [PAGE_W-1:0]           fill_off;

    assign lk_set  = lk_vaddr[OFF_W +: SET_W];
    assign lk_widx = lk_vaddr[BSEL_W +: WIDX_W];
    assign xl_vpn  = lk_vaddr[PAGE_W +: VPN_W];

    vipt_tag_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .PPN_W(PPN_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lu_set   (lk_set),
        .lu_ppn   (xl_ppn),
        .lu_match (match),
        .lu_victim(victim),
        .alloc_en (alloc),
        .done_en  (last_beat),
        .done_set (q.f_set),
        .done_way (q.f_way)
    );

    vipt_data_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .LINE_W(LINE_W),
        .WORD_W(WORD_W)
    ) u_data (
        .clk     (clk),
        .rd_set  (lk_set),
        .rd_lines(lines),
        .wr_en   (beat),
        .wr_set  (q.f_set),
        .wr_way  (q.f_way),
        .wr_idx  (q.f_cnt),
        .wr_data (fill_word)
    );

    vipt_way_select #(
        .WAYS  (WAYS),
        .LINE_W(LINE_W),
        .WORD_W(WORD_W)
    ) u_sel (
        .match(match),
        .lines(lines),
        .widx (lk_widx),
        .hit  (hit_any),
        .word (hit_word)
    );

    always_comb begin
        d         = q;
        lk_ready  = (q.st == ST_IDLE) && xl_ok;
        accept    = lk_valid && lk_ready;
        alloc     = accept && !hit_any;
        beat      = (q.st == ST_FILL) && fill_valid;
        last_beat = beat && (q.f_cnt == WIDX_W'(WPL - 1));

        d.rs_valid = accept;
        d.rs_hit   = accept && hit_any;
        if (accept) begin
            d.rs_data = hit_word;
        end

        if (alloc) begin
            d.st    = ST_FILL;
            d.f_set = lk_set;
            d.f_way = victim;
            d.f_ppn = xl_ppn;
            d.f_cnt = '0;
        end

        if (beat) begin
            d.f_cnt = q.f_cnt + WIDX_W'(1);
        end
        if (last_beat) begin
            d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign fill_off   = PAGE_W'({q.f_set, {OFF_W{1'b0}}});
    assign rs_valid   = q.rs_valid;
    assign rs_hit     = q.rs_hit;
    assign rs_data    = q.rs_data;
    assign fill_req   = (q.st == ST_FILL);
    assign fill_paddr = {q.f_ppn, fill_off};

    logic unused_va;
    assign unused_va = ^lk_vaddr;

    // R3: no translation, no result next cycle
    p_no_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && xl_ok) |=> !rs_valid);

    // R4: an accepted lookup reports one cycle later
    p_result_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rs_valid);

    // R5: a miss result comes with a pending refill
    p_miss_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> fill_req);

    // R5: refill address holds until words arrive
    p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> fill_req && $stable(fill_paddr));

    // R5: no lookup is taken while refilling
    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !lk_ready);
endmodule

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [23:0] lk_vaddr = '0;
    logic        lk_ready;
    logic [11:0] xl_vpn;
    logic [11:0] xl_ppn;
    logic        xl_ok = 1'b1;
    logic        rs_valid;
    logic        rs_hit;
    logic [31:0] rs_data;
    logic        fill_req;
    logic [23:0] fill_paddr;
    logic        fill_valid;
    logic [31:0] fill_word;

    logic [11:0] tlb_key = 12'h5A3;
    logic        alias_en = 1'b0;
    logic [11:0] alias_vpn = '0;
    logic [11:0] alias_ppn = '0;

    logic        auto_v = 1'b0;
    logic [31:0] auto_w = '0;
    logic        inj_v = 1'b0;
    logic [31:0] inj_w = '0;
    int          beat_n = 0;
    bit          gap_done = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign xl_ppn     = (alias_en && xl_vpn == alias_vpn) ? alias_ppn : (xl_vpn ^ tlb_key);
    assign fill_valid = auto_v | inj_v;
    assign fill_word  = auto_v ? auto_w : inj_w;

    vipt_cache uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .lk_ready  (lk_ready),
        .xl_vpn    (xl_vpn),
        .xl_ppn    (xl_ppn),
        .xl_ok     (xl_ok),
        .rs_valid  (rs_valid),
        .rs_hit    (rs_hit),
        .rs_data   (rs_data),
        .fill_req  (fill_req),
        .fill_paddr(fill_paddr),
        .fill_valid(fill_valid),
        .fill_word (fill_word)
    );

    function automatic logic [31:0] mem_word(input logic [23:0] pa);
        return {pa[23:2], 10'h2B5};
    endfunction

    function automatic logic [11:0] tlb(input logic [11:0] vpn);
        return (alias_en && vpn == alias_vpn) ? alias_ppn : (vpn ^ tlb_key);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // refill source: one pause in the middle of each line
    always @(negedge clk) begin
        if (fill_req && beat_n < 16) begin
            if (beat_n == 8 && !gap_done) begin
                auto_v   = 1'b0;
                gap_done = 1'b1;
            end else begin
                auto_v = 1'b1;
                auto_w = mem_word(fill_paddr + 24'(beat_n * 4));
                beat_n++;
            end
        end else begin
            auto_v = 1'b0;
            if (!fill_req) begin
                beat_n   = 0;
                gap_done = 1'b0;
            end
        end
    end

    task automatic lookup(input logic [23:0] va, output bit hit, output logic [31:0] data);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #1;
        while (!lk_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rs_valid === 1'b1, "R4 result valid one cycle after accept", 32'(rs_valid), 32'd1);
        hit  = rs_hit;
        data = rs_data;
        if (!rs_hit) begin
            chk(fill_req === 1'b1, "R5 refill requested on miss", 32'(fill_req), 32'd1);
            chk(fill_paddr === {tlb(va[23:12]), va[11:6], 6'b0}, "R5 refill line address",
                32'(fill_paddr), 32'({tlb(va[23:12]), va[11:6], 6'b0}));
            #1;
            chk(lk_ready === 1'b0, "R5 not ready during refill", 32'(lk_ready), 32'd0);
            while (fill_req) @(negedge clk);
        end
    endtask

    task automatic access(input logic [23:0] va, input bit exp_hit, input string tag);
        bit h;
        logic [31:0] dat;
        logic [23:0] pa;
        lookup(va, h, dat);
        pa = {tlb(va[23:12]), va[11:0]};
        chk(h == exp_hit, {tag, " hit/miss"}, 32'(h), 32'(exp_hit));
        if (exp_hit && h) begin
            chk(dat === mem_word(pa), {tag, " data"}, dat, mem_word(pa));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rs_valid === 1'b0, "R1 rs_valid low after reset", 32'(rs_valid), 32'd0);
        chk(fill_req === 1'b0, "R1 fill_req low after reset", 32'(fill_req), 32'd0);
        chk(lk_ready === 1'b1, "R1 ready with translation ok", 32'(lk_ready), 32'd1);
        access(24'h123048, 1'b0, "R1 first lookup misses");
    endtask

    task automatic t_vpn();
        @(negedge clk);
        lk_vaddr = 24'hABC123;
        #1;
        chk(xl_vpn === 12'hABC, "R2 vpn to translation", 32'(xl_vpn), 32'hABC);
        lk_vaddr = 24'h3C5FFF;
        #1;
        chk(xl_vpn === 12'h3C5, "R2 vpn to translation", 32'(xl_vpn), 32'h3C5);
    endtask

    task automatic t_fill_hits();
        // line at vpn 123, set 1 filled by t_reset; r6 words
        for (int k = 0; k < 16; k += 5) begin
            access({12'h123, 6'd1, 4'(k), 2'b00}, 1'b1, "R6 filled word");
        end
        access({12'h123, 6'd1, 4'd15, 2'b11}, 1'b1, "R2 low bits ignored");
        access({12'h123, 6'd1, 4'd9, 2'b00}, 1'b1, "R4 back-to-back hit");
    endtask

    task automatic t_stall();
        @(negedge clk);
        xl_ok    = 1'b0;
        lk_valid = 1'b1;
        lk_vaddr = 24'h123050;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(lk_ready === 1'b0, "R3 not ready without translation", 32'(lk_ready), 32'd0);
            @(negedge clk);
            chk(rs_valid === 1'b0, "R3 no result without translation", 32'(rs_valid), 32'd0);
        end
        lk_valid = 1'b0;
        xl_ok    = 1'b1;
        access(24'h123050, 1'b1, "R3 lookup after stall");
    endtask

    task automatic t_alias();
        alias_en  = 1'b1;
        alias_vpn = 12'h777;
        alias_ppn = 12'h123 ^ tlb_key;
        access({12'h777, 6'd1, 4'd3, 2'b00}, 1'b1, "R7 alias shares copy");
        alias_en = 1'b0;
    endtask

    task automatic t_retag();
        tlb_key = 12'h0F0;
        access(24'h123048, 1'b0, "R8 new physical page misses");
        tlb_key = 12'h5A3;
        access(24'h123048, 1'b1, "R8 old physical page still hits");
    endtask

    task automatic t_round_robin();
        for (int k = 0; k < 16; k++) begin
            access({12'(12'h200 + k), 6'd5, 6'd0}, 1'b0, "R9 fill set");
        end
        for (int k = 0; k < 16; k++) begin
            access({12'(12'h200 + k), 6'd5, 6'd4}, 1'b1, "R9 all ways resident");
        end
        access({12'h210, 6'd5, 6'd0}, 1'b0, "R9 seventeenth line");
        access({12'h200, 6'd5, 6'd0}, 1'b0, "R9 oldest line evicted");
        access({12'h202, 6'd5, 6'd8}, 1'b1, "R9 third line resident");
        access({12'h201, 6'd5, 6'd0}, 1'b0, "R9 second line evicted");
        access({12'h203, 6'd5, 6'd8}, 1'b1, "R9 fourth line resident");
    endtask

    task automatic t_stray_fill();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            inj_v = 1'b1;
            inj_w = 32'hDEAD0000 + 32'(i);
        end
        @(negedge clk);
        inj_v = 1'b0;
        chk(fill_req === 1'b0, "R11 stray beats start nothing", 32'(fill_req), 32'd0);
        chk(rs_valid === 1'b0, "R11 stray beats give no result", 32'(rs_valid), 32'd0);
        for (int k = 0; k < 16; k += 3) begin
            access({12'h123, 6'd1, 4'(k), 2'b00}, 1'b1, "R11 data unchanged");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_vpn();
        t_fill_hits();
        t_stall();
        t_alias();
        t_retag();
        t_round_robin();
        t_stray_fill();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule